// File: doc/BRIEF.md
# Register Mapping Table Renamer

This block keeps the live mapping from architectural registers to rename buffers for a two-wide issue stage. It has one entry for each architectural register. Each entry holds a flag that says whether the register is currently renamed, and the index of the rename buffer that will hold its newest value. Every cycle the block answers four source lookups, two for each instruction of the issue group, and takes up to two new destination mappings, one per instruction.

The lookups see the table as it stood at the start of the cycle. There is one exception. When the second instruction reads a register that the first instruction of the same group writes, the second instruction gets the first instruction's new buffer directly. A reclaim request clears an entry once its buffer is retired, but only if the entry still points at that buffer. A flush drops every mapping at once. Allocating buffers, storing operands and ordering completion are done outside this block.

Top module: `regMapRenamer`

## Requirements
- R1: After reset every entry is unrenamed, so all four lookups return flag 0 and index 0.
- R2: A lookup of a renamed register returns flag 1 and the stored buffer index. A lookup of an unrenamed register returns flag 0 and index 0.
- R3: When a destination strobe is high, the named register maps to the given buffer index from the next cycle on.
- R4: A later destination write to a register that is already renamed replaces its buffer index.
- R5: All lookups read the state from before this cycle's writes. An instruction's sources never see its own destination or a destination of slot 1 in the same cycle.
- R6: A slot 1 source equal to the slot 0 destination, with the slot 0 destination strobe high, returns flag 1 and slot 0's new buffer index. With that strobe low, no bypass takes place.
- R7: When both slots write the same register in one cycle, the table keeps slot 1's buffer index.
- R8: A reclaim whose buffer index equals the index stored in the named renamed entry clears that entry's flag.
- R9: A reclaim whose buffer index differs from the stored index leaves the entry unchanged.
- R10: Flush clears every entry in one cycle. Destination writes and reclaims in the same cycle are dropped.
- R11: When a destination write and a matching reclaim name the same register in the same cycle, the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Drop every mapping |
| dstEn0 | input | 1 | Slot 0 writes a destination |
| dstArch0 | input | 5 | Slot 0 destination register |
| newBuf0 | input | 4 | Buffer index allocated to slot 0 |
| srcA0 | input | 5 | Slot 0 first source register |
| srcB0 | input | 5 | Slot 0 second source register |
| dstEn1 | input | 1 | Slot 1 writes a destination |
| dstArch1 | input | 5 | Slot 1 destination register |
| newBuf1 | input | 4 | Buffer index allocated to slot 1 |
| srcA1 | input | 5 | Slot 1 first source register |
| srcB1 | input | 5 | Slot 1 second source register |
| recEn | input | 1 | Reclaim request |
| recArch | input | 5 | Register of the reclaimed mapping |
| recBuf | input | 4 | Buffer index being reclaimed |
| renA0 | output | 1 | Slot 0 source A is renamed |
| bufA0 | output | 4 | Slot 0 source A buffer index |
| renB0 | output | 1 | Slot 0 source B is renamed |
| bufB0 | output | 4 | Slot 0 source B buffer index |
| renA1 | output | 1 | Slot 1 source A is renamed |
| bufA1 | output | 4 | Slot 1 source A buffer index |
| renB1 | output | 1 | Slot 1 source B is renamed |
| bufB1 | output | 4 | Slot 1 source B buffer index |

## Verification
The hardest case is a stale reclaim, where the buffer being reclaimed is no longer the entry's newest mapping. To reach it, the stimulus first renames a register twice in a single group so that slot 1's mapping replaces slot 0's. It then reclaims the older buffer index and looks the register up again on the following cycle. A second sequence lines up a matching reclaim with a new write to the same register in one cycle. A third raises flush in the same cycle as two destination writes, then checks that neither write survived.

// File: rtl/renamePkg.sv
package renamePkg;

  // Strobes the control sends to the table datapath for one cycle.
  typedef struct packed {
    logic wipe;   // clear every entry
    logic wr0;    // slot 0 destination write
    logic wr1;    // slot 1 destination write
    logic clr;    // reclaim clears the named entry
    logic byp1a;  // slot 1 source A takes slot 0's new buffer
    logic byp1b;  // slot 1 source B takes slot 0's new buffer
  } mapStrobes_t;

endpackage

// File: rtl/mapCtrl.sv
module mapCtrl
  import renamePkg::*;
#(
  parameter int ARCH_W = 5,
  parameter int BUF_W  = 4
) (
  input  logic              flush,
  input  logic              dstEn0,
  input  logic [ARCH_W-1:0] dstArch0,
  input  logic              dstEn1,
  input  logic [ARCH_W-1:0] dstArch1,
  input  logic [ARCH_W-1:0] srcA1,
  input  logic [ARCH_W-1:0] srcB1,
  input  logic              recEn,
  input  logic [BUF_W-1:0]  recBuf,
  input  logic              entRecValid,
  input  logic [BUF_W-1:0]  entRecBuf,
  output mapStrobes_t       stb
);

  logic sameDst;
  logic recMatch;

  always_comb begin
    sameDst   = dstEn0 && dstEn1 && (dstArch0 == dstArch1);
    recMatch  = entRecValid && (entRecBuf == recBuf);
    stb.wipe  = flush;
    stb.wr1   = dstEn1 && !flush;
    // Slot 1 is younger, so slot 0's write is dropped when both name one register.
    stb.wr0   = dstEn0 && !flush && !sameDst;
    // Only a reclaim of the newest mapping may clear the entry.
    stb.clr   = recEn && !flush && recMatch;
    stb.byp1a = dstEn0 && (dstArch0 == srcA1);
    stb.byp1b = dstEn0 && (dstArch0 == srcB1);
  end

endmodule

// File: rtl/mapData.sv
module mapData
  import renamePkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int BUF_W    = 4,
  localparam int ARCH_W  = $clog2(NUM_ARCH),
  localparam int NUM_RD  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  mapStrobes_t                   stb,
  input  logic [ARCH_W-1:0]             dstArch0,
  input  logic [BUF_W-1:0]              newBuf0,
  input  logic [ARCH_W-1:0]             dstArch1,
  input  logic [BUF_W-1:0]              newBuf1,
  input  logic [ARCH_W-1:0]             recArch,
  input  logic [NUM_RD-1:0][ARCH_W-1:0] srcIdx,
  output logic                          recValid,
  output logic [BUF_W-1:0]              recBufCur,
  output logic [NUM_RD-1:0]             lkRen,
  output logic [NUM_RD-1:0][BUF_W-1:0]  lkBuf
);

  logic [NUM_ARCH-1:0] entValid;
  logic [BUF_W-1:0]    entBuf [NUM_ARCH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      for (int e = 0; e < NUM_ARCH; e++) entBuf[e] <= '0;
    end else if (stb.wipe) begin
      entValid <= '0;
    end else begin
      for (int e = 0; e < NUM_ARCH; e++) begin
        if (stb.wr1 && dstArch1 == ARCH_W'(e)) begin
          entValid[e] <= 1'b1;
          entBuf[e]   <= newBuf1;
        end else if (stb.wr0 && dstArch0 == ARCH_W'(e)) begin
          entValid[e] <= 1'b1;
          entBuf[e]   <= newBuf0;
        end else if (stb.clr && recArch == ARCH_W'(e)) begin
          entValid[e] <= 1'b0;
        end
      end
    end
  end

  assign recValid  = entValid[recArch];
  assign recBufCur = entBuf[recArch];

  // Read ports 0,1 serve slot 0; ports 2,3 serve slot 1 and may bypass.
  for (genvar p = 0; p < NUM_RD; p++) begin : gRead
    logic             rawRen;
    logic [BUF_W-1:0] rawBuf;
    logic             byp;
    assign rawRen = entValid[srcIdx[p]];
    assign rawBuf = rawRen ? entBuf[srcIdx[p]] : '0;
    if (p == 2) begin : gBypA
      assign byp = stb.byp1a;
    end else if (p == 3) begin : gBypB
      assign byp = stb.byp1b;
    end else begin : gNoByp
      assign byp = 1'b0;
    end
    assign lkRen[p] = byp | rawRen;
    assign lkBuf[p] = byp ? newBuf0 : rawBuf;
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    stb.wipe |=> (entValid == '0)); // R10

  AST_WR1_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    stb.wr1 |=> (entValid[$past(dstArch1)] && entBuf[$past(dstArch1)] == $past(newBuf1))); // R7

  AST_WR0_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    stb.wr0 |=> (entValid[$past(dstArch0)] && entBuf[$past(dstArch0)] == $past(newBuf0))); // R3

  AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wr0 && stb.wr1 && dstArch0 == dstArch1)); // R7

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clr && !(stb.wr1 && dstArch1 == recArch) && !(stb.wr0 && dstArch0 == recArch))
      |=> !entValid[$past(recArch)]); // R8

  AST_CLR_ONLY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |-> recValid); // R9

endmodule

// File: rtl/regMapRenamer.sv
module regMapRenamer
  import renamePkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int NUM_BUF  = 16,
  localparam int ARCH_W  = $clog2(NUM_ARCH),
  localparam int BUF_W   = $clog2(NUM_BUF)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              dstEn0,
  input  logic [ARCH_W-1:0] dstArch0,
  input  logic [BUF_W-1:0]  newBuf0,
  input  logic [ARCH_W-1:0] srcA0,
  input  logic [ARCH_W-1:0] srcB0,
  input  logic              dstEn1,
  input  logic [ARCH_W-1:0] dstArch1,
  input  logic [BUF_W-1:0]  newBuf1,
  input  logic [ARCH_W-1:0] srcA1,
  input  logic [ARCH_W-1:0] srcB1,
  input  logic              recEn,
  input  logic [ARCH_W-1:0] recArch,
  input  logic [BUF_W-1:0]  recBuf,
  output logic              renA0,
  output logic [BUF_W-1:0]  bufA0,
  output logic              renB0,
  output logic [BUF_W-1:0]  bufB0,
  output logic              renA1,
  output logic [BUF_W-1:0]  bufA1,
  output logic              renB1,
  output logic [BUF_W-1:0]  bufB1
);

  mapStrobes_t          stb;
  logic                 recValid;
  logic [BUF_W-1:0]     recBufCur;
  logic [3:0]           lkRen;
  logic [3:0][BUF_W-1:0] lkBuf;

  mapCtrl #(.ARCH_W(ARCH_W), .BUF_W(BUF_W)) uCtrl (
    .flush(flush), .dstEn0(dstEn0), .dstArch0(dstArch0),
    .dstEn1(dstEn1), .dstArch1(dstArch1), .srcA1(srcA1), .srcB1(srcB1),
    .recEn(recEn), .recBuf(recBuf), .entRecValid(recValid),
    .entRecBuf(recBufCur), .stb(stb)
  );

  mapData #(.NUM_ARCH(NUM_ARCH), .BUF_W(BUF_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .dstArch0(dstArch0), .newBuf0(newBuf0),
    .dstArch1(dstArch1), .newBuf1(newBuf1), .recArch(recArch),
    .srcIdx({srcB1, srcA1, srcB0, srcA0}),
    .recValid(recValid), .recBufCur(recBufCur),
    .lkRen(lkRen), .lkBuf(lkBuf)
  );

  assign renA0 = lkRen[0];
  assign bufA0 = lkBuf[0];
  assign renB0 = lkRen[1];
  assign bufB0 = lkBuf[1];
  assign renA1 = lkRen[2];
  assign bufA1 = lkBuf[2];
  assign renB1 = lkRen[3];
  assign bufB1 = lkBuf[3];

  AST_GROUP_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    (dstEn0 && dstArch0 == srcA1) |-> (renA1 && bufA1 == newBuf0)); // R6

  AST_UNRENAMED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !renA0 |-> (bufA0 == '0)); // R2

endmodule

// File: tb/tb_regMapRenamer.sv
module tb_regMapRenamer;

  typedef struct packed {
    logic       fl;
    logic       e0;
    logic [4:0] d0;
    logic [3:0] b0;
    logic       e1;
    logic [4:0] d1;
    logic [3:0] b1;
    logic       re;
    logic [4:0] ra;
    logic [3:0] rb;
    logic [4:0] sA0;
    logic [4:0] sB0;
    logic [4:0] sA1;
    logic [4:0] sB1;
    logic [4:0] xA0;  // expected {flag, index}
    logic [4:0] xB0;
    logic [4:0] xA1;
    logic [4:0] xB1;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    // V0 R1: nothing renamed after reset
    '{1'b0,1'b0,5'd0,4'd0,1'b0,5'd0,4'd0,1'b0,5'd0,4'd0, 5'd1,5'd2,5'd3,5'd4, 5'h00,5'h00,5'h00,5'h00, 4'd1},
    // V1 R5 R6: r5->3, r6->7; slot 1 A bypasses, own destinations unseen
    '{1'b0,1'b1,5'd5,4'd3,1'b1,5'd6,4'd7,1'b0,5'd0,4'd0, 5'd5,5'd6,5'd5,5'd6, 5'h00,5'h00,5'h13,5'h00, 4'd5},
    // V2 R3 R2: mappings visible next cycle; r7 unrenamed
    '{1'b0,1'b0,5'd0,4'd0,1'b0,5'd0,4'd0,1'b0,5'd0,4'd0, 5'd5,5'd6,5'd7,5'd5, 5'h13,5'h17,5'h00,5'h13, 4'd3},
    // V3 R7: both slots write r5 (9, then 10)
    '{1'b0,1'b1,5'd5,4'd9,1'b1,5'd5,4'd10,1'b0,5'd0,4'd0, 5'd5,5'd5,5'd5,5'd6, 5'h13,5'h13,5'h19,5'h17, 4'd7},
    // V4 R7: r5 holds 10; stale reclaim of buffer 3 issued
    '{1'b0,1'b0,5'd0,4'd0,1'b0,5'd0,4'd0,1'b1,5'd5,4'd3, 5'd5,5'd6,5'd0,5'd0, 5'h1A,5'h17,5'h00,5'h00, 4'd7},
    // V5 R9: stale reclaim ignored; matching reclaim of r6/7 issued
    '{1'b0,1'b0,5'd0,4'd0,1'b0,5'd0,4'd0,1'b1,5'd6,4'd7, 5'd5,5'd6,5'd0,5'd0, 5'h1A,5'h17,5'h00,5'h00, 4'd9},
    // V6 R8 R11: r6 cleared; r8->2 bypassed; r5 reclaim + write 11
    '{1'b0,1'b1,5'd8,4'd2,1'b1,5'd5,4'd11,1'b1,5'd5,4'd10, 5'd6,5'd5,5'd8,5'd8, 5'h00,5'h1A,5'h12,5'h12, 4'd8},
    // V7 R11 R4: r5 kept 11; r8 overwritten with 12
    '{1'b0,1'b1,5'd8,4'd12,1'b0,5'd0,4'd0,1'b0,5'd0,4'd0, 5'd5,5'd8,5'd9,5'd9, 5'h1B,5'h12,5'h00,5'h00, 4'd11},
    // V8 R4: r8 now 12; flush raised with two writes
    '{1'b1,1'b1,5'd9,4'd5,1'b1,5'd10,4'd6,1'b0,5'd0,4'd0, 5'd8,5'd5,5'd8,5'd1, 5'h1C,5'h1B,5'h1C,5'h00, 4'd4},
    // V9 R10: everything gone, flushed writes dropped
    '{1'b0,1'b0,5'd0,4'd0,1'b0,5'd0,4'd0,1'b0,5'd0,4'd0, 5'd8,5'd5,5'd9,5'd10, 5'h00,5'h00,5'h00,5'h00, 4'd10},
    // V10 R6: slot 0 strobe low, no bypass; slot 1 writes r31->15
    '{1'b0,1'b0,5'd31,4'd1,1'b1,5'd31,4'd15,1'b0,5'd0,4'd0, 5'd31,5'd0,5'd31,5'd31, 5'h00,5'h00,5'h00,5'h00, 4'd6},
    // V11 R3: r31 visible; stale reclaim of 14
    '{1'b0,1'b0,5'd0,4'd0,1'b0,5'd0,4'd0,1'b1,5'd31,4'd14, 5'd31,5'd31,5'd31,5'd0, 5'h1F,5'h1F,5'h1F,5'h00, 4'd3},
    // V12 R9: r31 kept after stale reclaim
    '{1'b0,1'b0,5'd0,4'd0,1'b0,5'd0,4'd0,1'b0,5'd0,4'd0, 5'd31,5'd0,5'd0,5'd0, 5'h1F,5'h00,5'h00,5'h00, 4'd9}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       flush, dstEn0, dstEn1, recEn;
  logic [4:0] dstArch0, dstArch1, srcA0, srcB0, srcA1, srcB1, recArch;
  logic [3:0] newBuf0, newBuf1, recBuf;
  logic       renA0, renB0, renA1, renB1;
  logic [3:0] bufA0, bufB0, bufA1, bufB1;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  regMapRenamer dut (
    .clk(clk), .rstN(rstN), .flush(flush),
    .dstEn0(dstEn0), .dstArch0(dstArch0), .newBuf0(newBuf0), .srcA0(srcA0), .srcB0(srcB0),
    .dstEn1(dstEn1), .dstArch1(dstArch1), .newBuf1(newBuf1), .srcA1(srcA1), .srcB1(srcB1),
    .recEn(recEn), .recArch(recArch), .recBuf(recBuf),
    .renA0(renA0), .bufA0(bufA0), .renB0(renB0), .bufB0(bufB0),
    .renA1(renA1), .bufA1(bufA1), .renB1(renB1), .bufB1(bufB1)
  );

  task automatic chk(input int rq, input string lane, input logic [4:0] got, input logic [4:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL R%0d %s: got flag=%0b idx=%0d, expected flag=%0b idx=%0d",
               rq, lane, got[4], got[3:0], exp[4], exp[3:0]);
    end
  endtask

  task automatic idle();
    flush = 0; dstEn0 = 0; dstEn1 = 0; recEn = 0;
    dstArch0 = 0; dstArch1 = 0; newBuf0 = 0; newBuf1 = 0;
    recArch = 0; recBuf = 0; srcA0 = 0; srcB0 = 0; srcA1 = 0; srcB1 = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  initial begin
    idle();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      flush = VEC[v].fl;
      dstEn0 = VEC[v].e0; dstArch0 = VEC[v].d0; newBuf0 = VEC[v].b0;
      dstEn1 = VEC[v].e1; dstArch1 = VEC[v].d1; newBuf1 = VEC[v].b1;
      recEn = VEC[v].re; recArch = VEC[v].ra; recBuf = VEC[v].rb;
      srcA0 = VEC[v].sA0; srcB0 = VEC[v].sB0; srcA1 = VEC[v].sA1; srcB1 = VEC[v].sB1;
      #4;
      chk(int'(VEC[v].rq), "srcA0", {renA0, bufA0}, VEC[v].xA0);
      chk(int'(VEC[v].rq), "srcB0", {renB0, bufB0}, VEC[v].xB0);
      chk(int'(VEC[v].rq), "srcA1", {renA1, bufA1}, VEC[v].xA1);
      chk(int'(VEC[v].rq), "srcB1", {renB1, bufB1}, VEC[v].xB1);
    end

    // R1: reset in mid-run drops the r31 mapping
    @(negedge clk);
    idle();
    rstN = 1'b0;
    srcA0 = 5'd31; srcB0 = 5'd31; srcA1 = 5'd31; srcB1 = 5'd31;
    #2;
    chk(1, "srcA0 during reset", {renA0, bufA0}, 5'h00);
    chk(1, "srcB1 during reset", {renB1, bufB1}, 5'h00);
    @(negedge clk);
    rstN = 1'b1;
    #4;
    chk(1, "srcA1 after reset", {renA1, bufA1}, 5'h00);

    // R8: a matching reclaim of an entry with index 0 clears it
    @(negedge clk);
    dstEn0 = 1; dstArch0 = 5'd3; newBuf0 = 4'd0;
    @(negedge clk);
    idle();
    srcA0 = 5'd3;
    #4;
    chk(3, "srcA0 index zero mapping", {renA0, bufA0}, 5'h10);
    @(negedge clk);
    recEn = 1; recArch = 5'd3; recBuf = 4'd0;
    @(negedge clk);
    idle();
    srcA0 = 5'd3;
    #4;
    chk(8, "srcA0 after reclaim", {renA0, bufA0}, 5'h00);

    finished = 1'b1;
    summary();
  end

endmodule